// File: doc/BRIEF.md
# SPI FIFO Status Flags and Receive Timeout

This block produces the four status flags of an SPI controller that buffers transmit and receive words in FIFOs with programmable watermark levels. It watches the occupancy counts reported by the two FIFOs, the busy state of the transmit shifter and the mode setting. From these it derives a transmit-space flag, a fully-idle transmit flag and a receive-data-ready flag. In buffered mode the transmit-space and receive-ready flags compare the FIFO fill level against software watermarks. In single-buffer mode they follow plain occupancy.

It also holds the receive timeout. A counter advances while buffered mode is on, the receive FIFO holds data and a nonzero compare value is programmed. Every read of receive data and every newly received word returns it to zero. When it reaches the compare value it raises a sticky flag, and software clears that flag by writing one. The FIFOs, the shifter and the register file stay outside the block. The flags are registered, so each flag follows its inputs one clock later.

Top module: `spi_fifo_flags`

## Requirements
- R1: After reset, tx_space_o and tx_idle_o read 1, and rx_ready_o and rx_timeout_o read 0.
- R2: With fifo_mode_i=1, tx_space_o is 1 one cycle after tx_level_i <= tx_wmark_i and 0 one cycle after tx_level_i > tx_wmark_i.
- R3: With fifo_mode_i=0, tx_space_o is 1 one cycle after tx_level_i == 0 and 0 otherwise. tx_wmark_i has no effect.
- R4: In either mode, tx_idle_o is 1 one cycle after tx_level_i == 0 and shift_busy_i == 0, and 0 if either one holds data.
- R5: With fifo_mode_i=1, rx_ready_o is 1 one cycle after rx_level_i >= rx_wmark_i and 0 one cycle after the level falls below it. A watermark of 0 acts as 1, so an empty FIFO never reports ready.
- R6: With fifo_mode_i=0, rx_ready_o is 1 one cycle after rx_level_i != 0 and 0 otherwise. rx_wmark_i has no effect.
- R7: With fifo_mode_i=1, toc_limit_i=N>0 and a nonempty receive FIFO, the counter starts from zero and rx_timeout_o rises after exactly N+1 clock edges with no read or receive strobe.
- R8: The counter holds at zero and rx_timeout_o does not rise while toc_limit_i is 0, while fifo_mode_i is 0, or while rx_level_i is 0.
- R9: A pulse on rx_read_i or rx_recv_i returns the counter to zero, so the N+1 edge count restarts after the pulse edge.
- R10: rx_timeout_o stays set, even after the FIFO empties, until a cycle with to_clear_i=1 and no set condition. It is 0 after that edge.
- R11: Once the counter reaches the compare value it holds there and does not wrap, so the set condition persists for as long as no restart occurs.
- R12: When the set condition and to_clear_i occur in the same cycle, rx_timeout_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 selects buffered (FIFO) mode, 0 selects single-buffer mode |
| tx_level_i | input | LVL_W | Transmit FIFO fill count (0 or 1 in single-buffer mode) |
| rx_level_i | input | LVL_W | Receive FIFO fill count (0 or 1 in single-buffer mode) |
| shift_busy_i | input | 1 | Transmit shift register holds data |
| tx_wmark_i | input | LVL_W | Transmit watermark |
| rx_wmark_i | input | LVL_W | Receive watermark |
| toc_limit_i | input | TOC_W | Timeout compare value, 0 disables |
| rx_read_i | input | 1 | Single-cycle strobe: receive data was read |
| rx_recv_i | input | 1 | Single-cycle strobe: a new word was received |
| to_clear_i | input | 1 | Write-one-to-clear strobe for the timeout flag |
| tx_space_o | output | 1 | Transmit buffer empty / FIFO at or below watermark |
| tx_idle_o | output | 1 | Transmit buffer and shifter both empty |
| rx_ready_o | output | 1 | Receive data available / FIFO at or above watermark |
| rx_timeout_o | output | 1 | Sticky receive timeout flag |

## Verification
The bench builds the block with an 8-deep FIFO count (4-bit levels) and a 4-bit timeout compare. The 4-bit compare lets a run hold the counter at its maximum value of 15 for longer than the 16-count wrap period, so a counter that wraps instead of saturating shows up within a few dozen cycles. The registered-flag variant is used, so every flag check is taken one edge after its inputs change. The shallow level width lets the watermark compares be exercised at both boundaries, including the zero watermark.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  typedef enum logic [0:0] {
    MODE_SINGLE = 1'b0,
    MODE_FIFO   = 1'b1
  } buf_mode_e;

  typedef struct packed {
    logic tx_space;
    logic tx_idle;
    logic rx_ready;
  } lvl_flags_t;

  localparam lvl_flags_t FLAGS_RST = '{tx_space: 1'b1, tx_idle: 1'b1, rx_ready: 1'b0};
endpackage

// File: rtl/tx_flag_gen.sv
module tx_flag_gen
  import spi_flag_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter bit FLAG_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  buf_mode_e        mode_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] wmark_i,
  input  logic             busy_i,
  output logic             space_o,
  output logic             idle_o
);
  logic space_d, idle_d;
  logic lvl_zero;

  assign lvl_zero = (level_i == '0);

  always_comb begin
    unique case (mode_i)
      MODE_FIFO:   space_d = (level_i <= wmark_i);
      default:     space_d = lvl_zero;
    endcase
    idle_d = lvl_zero & ~busy_i;
  end

  if (FLAG_REG) begin : g_reg
    logic space_q, idle_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        space_q <= FLAGS_RST.tx_space;
        idle_q  <= FLAGS_RST.tx_idle;
      end else begin
        space_q <= space_d;
        idle_q  <= idle_d;
      end
    end
    assign space_o = space_q;
    assign idle_o  = idle_q;

    AST_TX_ABOVE_WMARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_FIFO && level_i > wmark_i) |=> !space_o); // R2
    AST_TX_SINGLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_SINGLE && level_i == '0) |=> space_o); // R3
    AST_TX_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_i != '0 || busy_i) |=> !idle_o); // R4
  end else begin : g_comb
    assign space_o = space_d;
    assign idle_o  = idle_d;
  end
endmodule

// File: rtl/rx_flag_gen.sv
module rx_flag_gen
  import spi_flag_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter bit FLAG_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  buf_mode_e        mode_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] wmark_i,
  output logic             ready_o
);
  logic [LVL_W-1:0] eff_wmark;
  logic             ready_d;

  // zero watermark would flag an empty FIFO; floor it at one
  assign eff_wmark = (wmark_i == '0) ? LVL_W'(1) : wmark_i;

  always_comb begin
    unique case (mode_i)
      MODE_FIFO: ready_d = (level_i >= eff_wmark);
      default:   ready_d = (level_i != '0);
    endcase
  end

  if (FLAG_REG) begin : g_reg
    logic ready_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ready_q <= FLAGS_RST.rx_ready;
      else         ready_q <= ready_d;
    end
    assign ready_o = ready_q;

    AST_RX_EMPTY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_i == '0) |=> !ready_o); // R5
    AST_RX_SINGLE_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_SINGLE && level_i != '0) |=> ready_o); // R6
  end else begin : g_comb
    assign ready_o = ready_d;
  end
endmodule

// File: rtl/rx_timeout_ctr.sv
module rx_timeout_ctr
  import spi_flag_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int TOC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  buf_mode_e        mode_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [TOC_W-1:0] limit_i,
  input  logic             rx_read_i,
  input  logic             rx_recv_i,
  input  logic             clear_i,
  output logic             flag_o
);
  logic [TOC_W-1:0] cnt_q;
  logic             flag_q;
  logic             run_en, restart, set_cond;

  assign run_en   = (mode_i == MODE_FIFO) && (limit_i != '0) && (rx_level_i != '0);
  assign restart  = rx_read_i | rx_recv_i;
  assign set_cond = run_en && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_en || restart) begin
      cnt_q <= '0;
    end else if (cnt_q < limit_i) begin
      cnt_q <= cnt_q + TOC_W'(1);
    end
  end

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (set_cond) flag_q <= 1'b1;
    else if (clear_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_CNT_HELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en |=> (cnt_q == '0)); // R8
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en && restart) |=> (cnt_q == '0)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clear_i) |=> flag_o); // R10
  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en && !restart && $stable(limit_i) && cnt_q == limit_i) |=> (cnt_q == limit_i)); // R11
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_cond && clear_i) |=> flag_o); // R12
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
  import spi_flag_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TOC_W      = 16,
  parameter bit FLAG_REG   = 1'b1,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_mode_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             shift_busy_i,
  input  logic [LVL_W-1:0] tx_wmark_i,
  input  logic [LVL_W-1:0] rx_wmark_i,
  input  logic [TOC_W-1:0] toc_limit_i,
  input  logic             rx_read_i,
  input  logic             rx_recv_i,
  input  logic             to_clear_i,
  output logic             tx_space_o,
  output logic             tx_idle_o,
  output logic             rx_ready_o,
  output logic             rx_timeout_o
);
  buf_mode_e mode;
  assign mode = fifo_mode_i ? MODE_FIFO : MODE_SINGLE;

  tx_flag_gen #(.LVL_W(LVL_W), .FLAG_REG(FLAG_REG)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .level_i (tx_level_i),
    .wmark_i (tx_wmark_i),
    .busy_i  (shift_busy_i),
    .space_o (tx_space_o),
    .idle_o  (tx_idle_o)
  );

  rx_flag_gen #(.LVL_W(LVL_W), .FLAG_REG(FLAG_REG)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .level_i (rx_level_i),
    .wmark_i (rx_wmark_i),
    .ready_o (rx_ready_o)
  );

  rx_timeout_ctr #(.LVL_W(LVL_W), .TOC_W(TOC_W)) u_to (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .rx_level_i (rx_level_i),
    .limit_i    (toc_limit_i),
    .rx_read_i  (rx_read_i),
    .rx_recv_i  (rx_recv_i),
    .clear_i    (to_clear_i),
    .flag_o     (rx_timeout_o)
  );

  AST_RESET_VALUES: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni || (!rx_timeout_o && !rx_ready_o) || $past(rst_ni) == 1'b1)); // R1
endmodule

// File: tb/sim_spi_fifo_flags.sv
module sim_spi_fifo_flags;
  localparam int DEPTH = 8;
  localparam int TW    = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_mode = 1'b0;
  logic [LW-1:0] tx_lvl = '0, rx_lvl = '0, tx_wm = '0, rx_wm = '0;
  logic          busy = 1'b0;
  logic [TW-1:0] toc = '0;
  logic          rd = 1'b0, rcv = 1'b0, clr = 1'b0;
  logic          tx_space, tx_idle, rx_ready, rx_to;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_fifo_flags #(.FIFO_DEPTH(DEPTH), .TOC_W(TW), .FLAG_REG(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_mode_i(fifo_mode),
    .tx_level_i(tx_lvl), .rx_level_i(rx_lvl), .shift_busy_i(busy),
    .tx_wmark_i(tx_wm), .rx_wmark_i(rx_wm), .toc_limit_i(toc),
    .rx_read_i(rd), .rx_recv_i(rcv), .to_clear_i(clr),
    .tx_space_o(tx_space), .tx_idle_o(tx_idle), .rx_ready_o(rx_ready), .rx_timeout_o(rx_to)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 tx_space", tx_space, 1'b1);
    chk("R1 tx_idle", tx_idle, 1'b1);
    chk("R1 rx_ready", rx_ready, 1'b0);
    chk("R1 rx_timeout", rx_to, 1'b0);
  endtask

  task automatic t_tx_fifo;
    fifo_mode = 1'b1; tx_wm = 4'd3;
    tx_lvl = 4'd3; tick(1); chk("R2 level=wmark", tx_space, 1'b1);
    tx_lvl = 4'd4; tick(1); chk("R2 level>wmark", tx_space, 1'b0);
    tx_lvl = 4'd8; tick(1); chk("R2 full", tx_space, 1'b0);
    tx_lvl = 4'd0; tick(1); chk("R2 empty", tx_space, 1'b1);
  endtask

  task automatic t_tx_single;
    fifo_mode = 1'b0; tx_wm = 4'd5;
    tx_lvl = 4'd1; tick(1); chk("R3 full ignores wmark", tx_space, 1'b0);
    tx_lvl = 4'd0; tx_wm = 4'd0; tick(1); chk("R3 empty", tx_space, 1'b1);
  endtask

  task automatic t_idle;
    fifo_mode = 1'b1; tx_lvl = 4'd0; busy = 1'b1; tick(1);
    chk("R4 shifter busy", tx_idle, 1'b0);
    busy = 1'b0; tx_lvl = 4'd2; tick(1);
    chk("R4 fifo nonempty", tx_idle, 1'b0);
    tx_lvl = 4'd0; tick(1);
    chk("R4 both empty", tx_idle, 1'b1);
  endtask

  task automatic t_rx_fifo;
    fifo_mode = 1'b1; rx_wm = 4'd4;
    rx_lvl = 4'd3; tick(1); chk("R5 below wmark", rx_ready, 1'b0);
    rx_lvl = 4'd4; tick(1); chk("R5 at wmark", rx_ready, 1'b1);
    rx_lvl = 4'd2; tick(1); chk("R5 dropped", rx_ready, 1'b0);
    rx_wm = 4'd0; rx_lvl = 4'd0; tick(1); chk("R5 zero wmark empty", rx_ready, 1'b0);
    rx_lvl = 4'd1; tick(1); chk("R5 zero wmark one word", rx_ready, 1'b1);
    rx_lvl = 4'd0; tick(1);
  endtask

  task automatic t_rx_single;
    fifo_mode = 1'b0; rx_wm = 4'd6;
    rx_lvl = 4'd1; tick(1); chk("R6 data ignores wmark", rx_ready, 1'b1);
    rx_lvl = 4'd0; tick(1); chk("R6 read out", rx_ready, 1'b0);
  endtask

  task automatic t_timeout;
    fifo_mode = 1'b1; toc = 4'd5; rx_lvl = 4'd0; tick(2);
    rx_lvl = 4'd2;
    tick(5); chk("R7 before limit", rx_to, 1'b0);
    tick(1); chk("R7 at limit", rx_to, 1'b1);
    rx_lvl = 4'd0; tick(6); chk("R10 sticky after empty", rx_to, 1'b1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R10 cleared", rx_to, 1'b0);
  endtask

  task automatic t_restart;
    fifo_mode = 1'b1; toc = 4'd5; rx_lvl = 4'd2;
    tick(3);
    rcv = 1'b1; tick(1); rcv = 1'b0;
    tick(2); chk("R9 recv restarts", rx_to, 1'b0);
    tick(2);
    rd = 1'b1; tick(1); rd = 1'b0;
    tick(5); chk("R9 read restarts", rx_to, 1'b0);
    tick(1); chk("R9 after restart", rx_to, 1'b1);
    rx_lvl = 4'd0; clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  task automatic t_disabled;
    fifo_mode = 1'b1; toc = 4'd0; rx_lvl = 4'd3; tick(40);
    chk("R8 zero limit", rx_to, 1'b0);
    fifo_mode = 1'b0; toc = 4'd3; rx_lvl = 4'd1; tick(20);
    chk("R8 single mode", rx_to, 1'b0);
    fifo_mode = 1'b1; rx_lvl = 4'd0; tick(20);
    chk("R8 empty fifo", rx_to, 1'b0);
  endtask

  task automatic t_saturate;
    fifo_mode = 1'b1; toc = 4'd15; rx_lvl = 4'd4;
    tick(40); chk("R11 flag after long run", rx_to, 1'b1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R11 counter still at limit", rx_to, 1'b1);
    tick(17);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R12 set beats clear", rx_to, 1'b1);
    rd = 1'b1; tick(1); rd = 1'b0;
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R10 clear after restart", rx_to, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_fifo();
    t_tx_single();
    t_idle();
    t_rx_fifo();
    t_rx_single();
    t_timeout();
    t_restart();
    t_disabled();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule